// File: doc/BRIEF.md
# Byte-Addressed Load/Store Unit

This unit turns one load or store request from an execution stage into a single access on a 16-bit data bus. It forms the effective address by adding a sign-extended 4-bit offset to a 16-bit base value. It places byte data on the correct lane of the bus with byte enables. For loads, it takes the addressed byte or word from the returned data and sign- or zero-extends it for the register file.

Accesses whose address falls in the top 4 KB of the address space go out on a separate peripheral port. All other addresses go to the memory port. A word access at an odd address never reaches either port. It finishes at once with an error flag.

Each accepted request raises a request line and holds it until the selected port answers with ready. The unit then reports completion with a one-cycle done pulse.

Top module: `lsu_unit`

## Requirements
- R1: The effective address is `base_i + sign_extend(offset_i)`, taken modulo 2^16. The offset is 4-bit two's complement, so it covers -8 to +7.
- R2: `func3_i[0]` = 1 selects a 16-bit word access. A word store drives all 16 data bits with byte enable `2'b11`.
- R3: For loads, `func3_i` = 000 returns the byte sign-extended, 001 returns the whole word, and 100 returns the byte zero-extended. In general, bit 2 set means zero extension.
- R4: Data is little-endian. For a word access, bits 7:0 belong to the even byte address and bits 15:8 to the following odd byte address.
- R5: A byte access at an even address uses bus bits 7:0 with byte enable `2'b01`. At an odd address it uses bits 15:8 with byte enable `2'b10`. A byte store places the low byte of `wdata_i` on both lanes. A byte load takes its byte from the addressed lane.
- R6: Effective addresses 0xF000 through 0xFFFF, including those reached by wrap-around, are requested on the `io_*` port. All lower addresses are requested on the `mem_*` port. The unit never requests both ports at once.
- R7: A word access at an odd effective address raises `done_o` and `misalign_o` together, one clock after the start is accepted. No bus request is made and `rd_we_o` stays low. Byte accesses at odd addresses are legal.
- R8: While a request waits for ready, the request line, address, byte enables, write data and write flag stay unchanged. `done_o` is high for exactly one cycle, in the cycle after the clock edge at which ready was seen. A completed load raises `rd_we_o` in that same cycle, with the extended data on `rd_data_o`.
- R9: `start_i` is ignored while an access is outstanding.
- R10: After reset, no request is made and `done_o`, `misalign_o` and `rd_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start one access (taken when idle) |
| is_store_i | input | 1 | 1 = store, 0 = load |
| func3_i | input | 3 | Width/extension code |
| base_i | input | 16 | Base address value |
| offset_i | input | 4 | Signed address offset |
| wdata_i | input | 16 | Store data |
| mem_req_o | output | 1 | Memory port request |
| mem_we_o | output | 1 | Memory port write flag |
| mem_addr_o | output | 16 | Memory port byte address |
| mem_be_o | output | 2 | Memory port byte enables |
| mem_wdata_o | output | 16 | Memory port write data |
| mem_ready_i | input | 1 | Memory port ready |
| mem_rdata_i | input | 16 | Memory port read data |
| io_req_o | output | 1 | Peripheral port request |
| io_we_o | output | 1 | Peripheral port write flag |
| io_addr_o | output | 16 | Peripheral port byte address |
| io_be_o | output | 2 | Peripheral port byte enables |
| io_wdata_o | output | 16 | Peripheral port write data |
| io_ready_i | input | 1 | Peripheral port ready |
| io_rdata_i | input | 16 | Peripheral port read data |
| done_o | output | 1 | One-cycle completion pulse |
| misalign_o | output | 1 | Odd-address word access rejected |
| rd_we_o | output | 1 | Register write enable for loads |
| rd_data_o | output | 16 | Extended load result |

## Verification
Two situations are the hardest to reach from the ports. The first is a start pulse that arrives while an access is still waiting. The bench's bus model withholds ready for several cycles and pulses `start_i` with a different store during that window. It then confirms that only the first access ever reaches the bus.

The second is the peripheral decode reached through address wrap-around. A small base combined with a negative offset must land in the top region. A separate case sits exactly at the 0xEFFF/0xF000 boundary and reaches it through a positive offset.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned OFF_W  = 4;
  localparam int unsigned BE_W   = DATA_W / 8;

  // func3 bit meaning
  localparam int unsigned F3_WORD_BIT = 0;
  localparam int unsigned F3_ZEXT_BIT = 2;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } lsu_state_e;
endpackage

// File: rtl/lsu_ea_gen.sv
module lsu_ea_gen #(
  parameter int unsigned AW          = 16,
  parameter int unsigned OW          = 4,
  parameter int unsigned IO_PREFIX_W = 4,
  parameter logic [IO_PREFIX_W-1:0] IO_PREFIX = '1
) (
  input  logic [AW-1:0] base_i,
  input  logic [OW-1:0] offset_i,
  input  logic          word_i,
  output logic [AW-1:0] ea_o,
  output logic          io_sel_o,
  output logic          misalign_o
);
  logic [AW-1:0] off_ext;

  assign off_ext    = {{(AW-OW){offset_i[OW-1]}}, offset_i};
  assign ea_o       = base_i + off_ext;
  assign io_sel_o   = (ea_o[AW-1 -: IO_PREFIX_W] == IO_PREFIX);
  assign misalign_o = word_i & ea_o[0];
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane #(
  parameter int unsigned DW = 16
) (
  input  logic              odd_i,
  input  logic              word_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW/8-1:0]   be_o,
  output logic [DW-1:0]     bus_wdata_o
);
  always_comb begin
    if (word_i) begin
      be_o        = '1;
      bus_wdata_o = wdata_i;
    end else begin
      be_o        = odd_i ? 2'b10 : 2'b01;
      bus_wdata_o = {wdata_i[7:0], wdata_i[7:0]};
    end
  end
endmodule

// File: rtl/lsu_load_lane.sv
module lsu_load_lane #(
  parameter int unsigned DW = 16
) (
  input  logic          odd_i,
  input  logic          word_i,
  input  logic          zext_i,
  input  logic [DW-1:0] rdata_i,
  output logic [DW-1:0] rd_data_o
);
  logic [7:0] lane_byte;

  assign lane_byte = odd_i ? rdata_i[15:8] : rdata_i[7:0];

  always_comb begin
    if (word_i)      rd_data_o = rdata_i;
    else if (zext_i) rd_data_o = {{(DW-8){1'b0}}, lane_byte};
    else             rd_data_o = {{(DW-8){lane_byte[7]}}, lane_byte};
  end
endmodule

// File: rtl/lsu_unit.sv
module lsu_unit
  import lsu_pkg::*;
#(
  parameter int unsigned IO_PREFIX_W = 4,
  parameter logic [IO_PREFIX_W-1:0] IO_PREFIX = 4'hF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              is_store_i,
  input  logic [2:0]        func3_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BE_W-1:0]   mem_be_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              io_req_o,
  output logic              io_we_o,
  output logic [ADDR_W-1:0] io_addr_o,
  output logic [BE_W-1:0]   io_be_o,
  output logic [DATA_W-1:0] io_wdata_o,
  input  logic              io_ready_i,
  input  logic [DATA_W-1:0] io_rdata_i,
  output logic              done_o,
  output logic              misalign_o,
  output logic              rd_we_o,
  output logic [DATA_W-1:0] rd_data_o
);
  lsu_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BE_W-1:0]   be_q;
  logic [DATA_W-1:0] wdata_q;
  logic              we_q, io_q, word_q, zext_q;
  logic              done_q, mis_q, rd_we_q;
  logic [DATA_W-1:0] rd_data_q;

  logic              word_req;
  logic [ADDR_W-1:0] ea;
  logic              ea_io, ea_mis;
  logic [BE_W-1:0]   st_be;
  logic [DATA_W-1:0] st_data;
  logic [DATA_W-1:0] rsp_data, ld_data;
  logic              rsp_ready;

  assign word_req = func3_i[F3_WORD_BIT];

  lsu_ea_gen #(
    .AW(ADDR_W), .OW(OFF_W), .IO_PREFIX_W(IO_PREFIX_W), .IO_PREFIX(IO_PREFIX)
  ) u_ea (
    .base_i(base_i), .offset_i(offset_i), .word_i(word_req),
    .ea_o(ea), .io_sel_o(ea_io), .misalign_o(ea_mis)
  );

  lsu_store_lane #(.DW(DATA_W)) u_st (
    .odd_i(ea[0]), .word_i(word_req), .wdata_i(wdata_i),
    .be_o(st_be), .bus_wdata_o(st_data)
  );

  assign rsp_data  = io_q ? io_rdata_i : mem_rdata_i;
  assign rsp_ready = io_q ? io_ready_i : mem_ready_i;

  lsu_load_lane #(.DW(DATA_W)) u_ld (
    .odd_i(addr_q[0]), .word_i(word_q), .zext_i(zext_q),
    .rdata_i(rsp_data), .rd_data_o(ld_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      be_q      <= '0;
      wdata_q   <= '0;
      we_q      <= 1'b0;
      io_q      <= 1'b0;
      word_q    <= 1'b0;
      zext_q    <= 1'b0;
      done_q    <= 1'b0;
      mis_q     <= 1'b0;
      rd_we_q   <= 1'b0;
      rd_data_q <= '0;
    end else begin
      done_q  <= 1'b0;
      mis_q   <= 1'b0;
      rd_we_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          if (ea_mis) begin
            // rejected before any bus activity
            done_q <= 1'b1;
            mis_q  <= 1'b1;
          end else begin
            addr_q  <= ea;
            be_q    <= st_be;
            wdata_q <= st_data;
            we_q    <= is_store_i;
            io_q    <= ea_io;
            word_q  <= word_req;
            zext_q  <= func3_i[F3_ZEXT_BIT];
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: if (rsp_ready) begin
          done_q  <= 1'b1;
          rd_we_q <= ~we_q;
          if (!we_q) rd_data_q <= ld_data;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o   = (state_q == ST_WAIT) & ~io_q;
  assign io_req_o    = (state_q == ST_WAIT) &  io_q;
  assign mem_we_o    = we_q;
  assign io_we_o     = we_q;
  assign mem_addr_o  = addr_q;
  assign io_addr_o   = addr_q;
  assign mem_be_o    = be_q;
  assign io_be_o     = be_q;
  assign mem_wdata_o = wdata_q;
  assign io_wdata_o  = wdata_q;
  assign done_o      = done_q;
  assign misalign_o  = mis_q;
  assign rd_we_o     = rd_we_q;
  assign rd_data_o   = rd_data_q;

  a_r6_one_port: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_o && io_req_o));

  a_r6_io_region: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_req_o |-> (io_addr_o[ADDR_W-1 -: IO_PREFIX_W] == IO_PREFIX));

  a_r7_word_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_be_o == 2'b11) |-> !mem_addr_o[0]);

  a_r7_no_write_on_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> (done_o && !rd_we_o));

  a_r8_mem_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) &&
      $stable(mem_be_o) && $stable(mem_wdata_o) && $stable(mem_we_o)));

  a_r8_io_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_req_o && !io_ready_i) |=> (io_req_o && $stable(io_addr_o) &&
      $stable(io_be_o) && $stable(io_wdata_o) && $stable(io_we_o)));

  a_r8_rdwe_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_we_o |-> done_o);

  a_r8_done_after_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ready_i) |=> (done_o && !mem_req_o));
endmodule

// File: tb/lsu_unit_tb_top.sv
`timescale 1ns/1ps
module lsu_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        start_i = 1'b0, is_store_i = 1'b0;
  logic [2:0]  func3_i = '0;
  logic [15:0] base_i = '0, wdata_i = '0;
  logic [3:0]  offset_i = '0;
  logic        mem_req_o, mem_we_o, mem_ready_i, io_req_o, io_we_o, io_ready_i;
  logic [15:0] mem_addr_o, mem_wdata_o, mem_rdata_i, io_addr_o, io_wdata_o, io_rdata_i;
  logic [1:0]  mem_be_o, io_be_o;
  logic        done_o, misalign_o, rd_we_o;
  logic [15:0] rd_data_o;

  lsu_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .is_store_i(is_store_i),
    .func3_i(func3_i), .base_i(base_i), .offset_i(offset_i), .wdata_i(wdata_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_be_o(mem_be_o), .mem_wdata_o(mem_wdata_o), .mem_ready_i(mem_ready_i),
    .mem_rdata_i(mem_rdata_i), .io_req_o(io_req_o), .io_we_o(io_we_o),
    .io_addr_o(io_addr_o), .io_be_o(io_be_o), .io_wdata_o(io_wdata_o),
    .io_ready_i(io_ready_i), .io_rdata_i(io_rdata_i), .done_o(done_o),
    .misalign_o(misalign_o), .rd_we_o(rd_we_o), .rd_data_o(rd_data_o)
  );

  // bus models
  logic [7:0]  ram [256];
  logic [7:0]  iom [256];
  int          lat = 0;
  int          mem_cnt = 0, io_cnt = 0;
  int          mem_txn = 0, io_txn = 0;
  logic [15:0] last_addr, last_wd;
  logic [1:0]  last_be;

  assign mem_ready_i = mem_req_o && (mem_cnt >= lat);
  assign io_ready_i  = io_req_o && (io_cnt >= lat);
  assign mem_rdata_i = {ram[{mem_addr_o[7:1], 1'b1}], ram[{mem_addr_o[7:1], 1'b0}]};
  assign io_rdata_i  = {iom[{io_addr_o[7:1], 1'b1}], iom[{io_addr_o[7:1], 1'b0}]};

  always @(posedge clk) begin
    if (mem_req_o && !mem_ready_i) mem_cnt <= mem_cnt + 1; else mem_cnt <= 0;
    if (io_req_o && !io_ready_i) io_cnt <= io_cnt + 1; else io_cnt <= 0;
    if (mem_req_o && mem_ready_i) begin
      if (mem_we_o && mem_be_o[0]) ram[{mem_addr_o[7:1], 1'b0}] <= mem_wdata_o[7:0];
      if (mem_we_o && mem_be_o[1]) ram[{mem_addr_o[7:1], 1'b1}] <= mem_wdata_o[15:8];
      mem_txn <= mem_txn + 1;
      last_addr <= mem_addr_o; last_be <= mem_be_o; last_wd <= mem_wdata_o;
    end
    if (io_req_o && io_ready_i) begin
      if (io_we_o && io_be_o[0]) iom[{io_addr_o[7:1], 1'b0}] <= io_wdata_o[7:0];
      if (io_we_o && io_be_o[1]) iom[{io_addr_o[7:1], 1'b1}] <= io_wdata_o[15:8];
      io_txn <= io_txn + 1;
      last_addr <= io_addr_o; last_be <= io_be_o; last_wd <= io_wdata_o;
    end
  end

  int checks = 0, errors = 0;
  logic        got_rdwe, got_mis;
  logic [15:0] got_data;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic st, input logic [2:0] f3, input logic [15:0] base,
                       input logic [3:0] off, input logic [15:0] wd);
    int n;
    @(negedge clk);
    start_i = 1'b1; is_store_i = st; func3_i = f3; base_i = base;
    offset_i = off; wdata_i = wd;
    @(negedge clk);
    start_i = 1'b0;
    n = 0;
    while (!done_o && n < 100) begin @(negedge clk); n++; end
    got_rdwe = rd_we_o; got_mis = misalign_o; got_data = rd_data_o;
  endtask

  task automatic t_reset;
    chk("R10 mem_req", {31'd0, mem_req_o}, 0);
    chk("R10 io_req", {31'd0, io_req_o}, 0);
    chk("R10 done/mis/rdwe", {29'd0, done_o, misalign_o, rd_we_o}, 0);
  endtask

  task automatic t_word;
    do_op(1, 3'b001, 16'h0010, 4'h0, 16'h1234);
    chk("R4 low byte at even", {24'd0, ram[8'h10]}, 32'h34);
    chk("R4 high byte at odd", {24'd0, ram[8'h11]}, 32'h12);
    chk("R2 word be", {30'd0, last_be}, 32'h3);
    chk("R2 store no rd_we", {31'd0, got_rdwe}, 0);
    do_op(0, 3'b001, 16'h0010, 4'h0, 16'h0);
    chk("R3 load word", {16'd0, got_data}, 32'h1234);
    chk("R8 load rd_we", {31'd0, got_rdwe}, 1);
  endtask

  task automatic t_offset;
    do_op(0, 3'b001, 16'h0018, 4'h8, 16'h0);
    chk("R1 neg offset addr", {16'd0, last_addr}, 32'h0010);
    chk("R1 neg offset data", {16'd0, got_data}, 32'h1234);
    do_op(1, 3'b000, 16'h000B, 4'h7, 16'h00A5);
    chk("R1 pos offset addr", {16'd0, last_addr}, 32'h0012);
  endtask

  task automatic t_byte;
    do_op(1, 3'b000, 16'h0011, 4'h0, 16'h77C3);
    chk("R5 odd be", {30'd0, last_be}, 32'h2);
    chk("R5 odd lane data", {24'd0, last_wd[15:8]}, 32'hC3);
    chk("R5 odd byte written", {24'd0, ram[8'h11]}, 32'hC3);
    chk("R5 even byte untouched", {24'd0, ram[8'h10]}, 32'h34);
    do_op(1, 3'b000, 16'h0010, 4'h0, 16'h1180);
    chk("R5 even be", {30'd0, last_be}, 32'h1);
    chk("R5 even lane data", {24'd0, last_wd[7:0]}, 32'h80);
    do_op(0, 3'b000, 16'h0010, 4'h0, 16'h0);
    chk("R3 signed byte", {16'd0, got_data}, 32'hFF80);
    do_op(0, 3'b100, 16'h0010, 4'h0, 16'h0);
    chk("R3 unsigned byte", {16'd0, got_data}, 32'h0080);
    do_op(0, 3'b000, 16'h0011, 4'h0, 16'h0);
    chk("R5 odd lane signed load", {16'd0, got_data}, 32'hFFC3);
    do_op(0, 3'b001, 16'h0010, 4'h0, 16'h0);
    chk("R4 word from bytes", {16'd0, got_data}, 32'hC380);
  endtask

  task automatic t_region;
    int m0, i0;
    m0 = mem_txn; i0 = io_txn;
    do_op(1, 3'b001, 16'hEFFF, 4'h1, 16'hCAFE);
    chk("R6 boundary to io", io_txn - i0, 1);
    chk("R6 boundary not mem", mem_txn - m0, 0);
    chk("R6 io addr", {16'd0, last_addr}, 32'hF000);
    chk("R6 io data", {16'd0, iom[8'h01], iom[8'h00]}, 32'hCAFE);
    m0 = mem_txn;
    do_op(1, 3'b000, 16'hEFFE, 4'h1, 16'h005A);
    chk("R6 0xEFFF stays mem", mem_txn - m0, 1);
    i0 = io_txn;
    do_op(1, 3'b000, 16'h0003, 4'h8, 16'h0066);
    chk("R6 wrap to io", io_txn - i0, 1);
    chk("R1 wrap addr", {16'd0, last_addr}, 32'hFFFB);
    chk("R5 wrap odd be", {30'd0, last_be}, 32'h2);
    do_op(0, 3'b100, 16'hFFFC, 4'hF, 16'h0);
    chk("R6 io byte readback", {16'd0, got_data}, 32'h0066);
  endtask

  task automatic t_misalign;
    int t0;
    t0 = mem_txn + io_txn;
    do_op(1, 3'b001, 16'h0011, 4'h0, 16'hBEEF);
    chk("R7 misalign flag", {31'd0, got_mis}, 1);
    chk("R7 no bus access", mem_txn + io_txn - t0, 0);
    chk("R7 memory unchanged", {16'd0, ram[8'h11], ram[8'h10]}, 32'hC380);
    do_op(0, 3'b001, 16'h0010, 4'h3, 16'h0);
    chk("R7 load misalign flag", {31'd0, got_mis}, 1);
    chk("R7 no rd write", {31'd0, got_rdwe}, 0);
    do_op(0, 3'b100, 16'h0011, 4'h0, 16'h0);
    chk("R7 odd byte legal", {31'd0, got_mis}, 0);
  endtask

  task automatic t_latency;
    int reqs, bad, n;
    logic [15:0] a0;
    lat = 3; reqs = 0; bad = 0; n = 0;
    @(negedge clk);
    start_i = 1'b1; is_store_i = 1'b0; func3_i = 3'b001; base_i = 16'h0010; offset_i = 4'h0;
    @(negedge clk);
    start_i = 1'b0;
    a0 = mem_addr_o;
    while (!done_o && n < 100) begin
      if (mem_req_o) reqs++;
      if (mem_addr_o !== a0 || mem_be_o !== 2'b11) bad++;
      @(negedge clk); n++;
    end
    chk("R8 request held cycles", reqs, 4);
    chk("R8 stable while waiting", bad, 0);
    chk("R8 data after wait", {16'd0, rd_data_o}, 32'hC380);
    @(negedge clk);
    chk("R8 done one cycle", {31'd0, done_o}, 0);
    lat = 0;
  endtask

  task automatic t_busy;
    int t0, n;
    lat = 4; t0 = mem_txn + io_txn; n = 0;
    @(negedge clk);
    start_i = 1'b1; is_store_i = 1'b0; func3_i = 3'b001; base_i = 16'h0010; offset_i = 4'h0;
    @(negedge clk);
    start_i = 1'b1; is_store_i = 1'b1; base_i = 16'h0020; wdata_i = 16'hDEAD;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o && n < 100) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
    chk("R9 single transaction", mem_txn + io_txn - t0, 1);
    chk("R9 first address kept", {16'd0, last_addr}, 32'h0010);
    lat = 0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_word();
    t_offset();
    t_byte();
    t_region();
    t_misalign();
    t_latency();
    t_busy();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule